// File: doc/BRIEF.md
# Infrared Receive Run-Length Buffer with Status

This block is the receive half of a consumer infrared controller. It takes a demodulated infrared line, samples it once per sample tick (one tick is TICK_CYCLES clocks, normally 50 µs), and measures how many ticks each pulse and each space lasts. Every run becomes one or more bytes holding a polarity bit and a tick count, which are queued in a small receive FIFO. A host reads bytes from a data register, programs an idle threshold, reads a drop counter, and services a status register that holds an interrupt enable bit and four sticky event flags. Two of the flags report transmit events that arrive on strobe inputs from a transmit path outside this block.

The receiver waits in an idle state until the line first shows a pulse. Once the line has stayed in space for the programmed number of ticks, the space run is closed and the receiver goes idle again, so a silent line never fills the queue. A single level-sensitive interrupt line is raised when the enable bit is set and any flag is set.

Top module: `cir_rx_top`

## Requirements
- R1: After reset the status register reads 0x00, irq is low, a data read returns 0x00, the threshold register reads IDLE_DEF and the drop counter reads 0.
- R2: Each queued byte has bit 7 = 1 for a pulse and 0 for a space, and bits 6:0 hold the run length in sample ticks, which is never 0.
- R3: A run longer than 127 ticks is emitted as 0x7F-count bytes of the same polarity followed by the remainder; a run that is an exact multiple of 127 leaves no zero-length byte.
- R4: Register address 2 holds the idle threshold; when a space reaches that many ticks (threshold of 2 or more) a final space byte is queued and nothing more is queued until the next pulse; threshold values 0 and 1 turn this off, so long spaces are split without end.
- R5: Bytes leave the FIFO (FIFO_DEPTH entries) in arrival order; each read of address 1 returns the oldest byte and removes it; a read of an empty FIFO returns 0x00 and changes nothing.
- R6: A byte that arrives while the FIFO is full and no byte leaves in that cycle is dropped, and the counter at address 3 increments, saturating at 255.
- R7: The status register (address 0) has bit 0 = data received, bit 1 = receive timeout, bit 2 = transmit underrun, bit 3 = transmit finished, bit 7 = interrupt enable (written directly); bits 6:4 read 0.
- R8: The transmit flags are set by one-cycle strobes on their inputs and cleared by writing 1 to them; writing 0 leaves them unchanged, and a strobe in the same cycle as a clearing write leaves the flag set.
- R9: Bit 0 is set when a byte enters the FIFO, bit 1 when the idle threshold is reached with the FIFO not empty; both fall to 0 when the FIFO becomes empty and host writes to these two bits have no effect.
- R10: irq is high exactly when the interrupt enable bit is 1 and at least one of the four flags is 1.
- R11: While blk_en is low every register read returns 0xFF, writes are ignored, data reads remove nothing and the receiver is held idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| blk_en | input | 1 | Block enable; low makes the block appear absent |
| ir_in | input | 1 | Demodulated infrared line, 1 = pulse |
| tx_underrun_evt | input | 1 | One-cycle strobe from the transmit path: underrun |
| tx_done_evt | input | 1 | One-cycle strobe from the transmit path: transmission finished |
| reg_addr | input | 2 | Register select: 0 status, 1 data, 2 idle threshold, 3 drop counter |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the FIFO at address 1) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register, combinational |
| irq | output | 1 | Interrupt request, level |

## Verification
The case that needs the most care is a transmit strobe that arrives in the same clock cycle as a status write that clears the same flag. The bench drives the tx_done_evt strobe and the clearing write on the same negative edge, so both are seen at one rising edge. It then reads the status register and expects the flag still set, with the interrupt still high. A later write alone must clear it.

// File: rtl/cir_rx_pkg.sv
package cir_rx_pkg;

    localparam int BYTE_W  = 8;
    localparam int RUN_W   = 7;
    localparam int RUN_MAX = (1 << RUN_W) - 1;

    // status flag positions (host software depends on them)
    localparam int F_RXDATA = 0;
    localparam int F_RXTMO  = 1;
    localparam int F_TXUND  = 2;
    localparam int F_TXDONE = 3;
    localparam int IRQEN_BIT = 7;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_RXDATA = 2'd1,
        SEL_IDLE   = 2'd2,
        SEL_DROPS  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic       irq_en;
        logic [3:0] flags;
    } status_t;

    typedef struct packed {
        logic             pulse;
        logic [RUN_W-1:0] ticks;
    } run_byte_t;

endpackage

// File: rtl/cir_rx_sampler.sv
module cir_rx_sampler #(
    parameter int TICK_CYCLES = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic ir_in,
    output logic tick,
    output logic level
);
    localparam int DIV_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_CYCLES - 1);

    typedef struct packed {
        logic [1:0]       sync;
        logic [DIV_W-1:0] div;
    } smp_t;

    smp_t smp_q, smp_d;

    always_comb begin
        smp_d      = smp_q;
        smp_d.sync = {smp_q.sync[0], ir_in};
        tick       = 1'b0;
        if (!en) begin
            smp_d.div = '0;
        end else if (smp_q.div == DIV_LAST) begin
            smp_d.div = '0;
            tick      = 1'b1;
        end else begin
            smp_d.div = smp_q.div + 1'b1;
        end
    end

    assign level = smp_q.sync[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) smp_q <= '0;
        else        smp_q <= smp_d;
    end
endmodule

// File: rtl/cir_rx_runlen.sv
module cir_rx_runlen
    import cir_rx_pkg::*;
#(
    parameter int THR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             level,
    input  logic [THR_W-1:0] idle_thr,
    output logic             push,
    output run_byte_t        push_byte,
    output logic             idle_hit
);
    typedef struct packed {
        logic             active;
        logic             lvl;
        logic [RUN_W-1:0] cnt;
        logic [THR_W-1:0] idle_cnt;
    } rl_t;

    rl_t              rl_q, rl_d;
    logic [RUN_W-1:0] cnt_inc;
    logic [THR_W-1:0] idle_inc;
    logic             thr_on;

    always_comb begin
        rl_d      = rl_q;
        push      = 1'b0;
        push_byte = '0;
        idle_hit  = 1'b0;
        cnt_inc   = rl_q.cnt + 1'b1;
        idle_inc  = (&rl_q.idle_cnt) ? rl_q.idle_cnt : rl_q.idle_cnt + 1'b1;
        thr_on    = (idle_thr > THR_W'(1));

        if (!en) begin
            rl_d = '0;
        end else if (tick) begin
            if (!rl_q.active) begin
                // wait for the first pulse sample
                if (level) begin
                    rl_d.active   = 1'b1;
                    rl_d.lvl      = 1'b1;
                    rl_d.cnt      = RUN_W'(1);
                    rl_d.idle_cnt = '0;
                end
            end else if (level != rl_q.lvl) begin
                // polarity change closes the running byte
                if (rl_q.cnt != '0) begin
                    push            = 1'b1;
                    push_byte.pulse = rl_q.lvl;
                    push_byte.ticks = rl_q.cnt;
                end
                rl_d.lvl      = level;
                rl_d.cnt      = RUN_W'(1);
                rl_d.idle_cnt = level ? '0 : THR_W'(1);
            end else begin
                if (!rl_q.lvl) rl_d.idle_cnt = idle_inc;
                if (!rl_q.lvl && thr_on && (idle_inc == idle_thr)) begin
                    push            = 1'b1;
                    push_byte.pulse = 1'b0;
                    push_byte.ticks = cnt_inc;
                    rl_d.active     = 1'b0;
                    rl_d.cnt        = '0;
                    rl_d.idle_cnt   = '0;
                    idle_hit        = 1'b1;
                end else if (cnt_inc == RUN_W'(RUN_MAX)) begin
                    push            = 1'b1;
                    push_byte.pulse = rl_q.lvl;
                    push_byte.ticks = cnt_inc;
                    rl_d.cnt        = '0;
                end else begin
                    rl_d.cnt = cnt_inc;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rl_q <= '0;
        else        rl_q <= rl_d;
    end
endmodule

// File: rtl/cir_rx_fifo.sv
module cir_rx_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     wdata,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic             empty,
    output logic             full,
    output logic             empty_next,
    output logic             pushed,
    output logic [CNT_W-1:0] drop_cnt
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wr;
        logic [AW-1:0]           rd;
        logic [LW-1:0]           lvl;
        logic [CNT_W-1:0]        drops;
    } ff_t;

    ff_t  ff_q, ff_d;
    logic do_pop;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        ff_d   = ff_q;
        do_pop = pop && (ff_q.lvl != '0);
        pushed = push && ((ff_q.lvl != LW'(DEPTH)) || do_pop);
        if (pushed) begin
            ff_d.mem[ff_q.wr] = wdata;
            ff_d.wr           = ptr_next(ff_q.wr);
        end else if (push && !(&ff_q.drops)) begin
            ff_d.drops = ff_q.drops + 1'b1;
        end
        if (do_pop) ff_d.rd = ptr_next(ff_q.rd);
        ff_d.lvl = ff_q.lvl + LW'(pushed) - LW'(do_pop);
    end

    assign head       = ff_q.mem[ff_q.rd];
    assign empty      = (ff_q.lvl == '0);
    assign full       = (ff_q.lvl == LW'(DEPTH));
    assign empty_next = (ff_d.lvl == '0);
    assign drop_cnt   = ff_q.drops;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff_q <= '0;
        else        ff_q <= ff_d;
    end
endmodule

// File: rtl/cir_rx_top.sv
module cir_rx_top
    import cir_rx_pkg::*;
#(
    parameter int TICK_CYCLES = 10000,
    parameter int FIFO_DEPTH  = 16,
    parameter int IDLE_DEF    = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       blk_en,
    input  logic       ir_in,
    input  logic       tx_underrun_evt,
    input  logic       tx_done_evt,
    input  logic [1:0] reg_addr,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq
);
    localparam int THR_W  = BYTE_W;
    localparam int DROP_W = BYTE_W;

    typedef struct packed {
        status_t          st;
        logic [THR_W-1:0] thr;
    } core_t;

    localparam core_t CORE_RST = '{st: '0, thr: THR_W'(IDLE_DEF)};

    core_t             core_q, core_d;
    logic              tick, level;
    logic              rl_push, idle_hit;
    run_byte_t         rl_byte;
    logic [BYTE_W-1:0] fifo_head;
    logic              fifo_empty, fifo_full, fifo_empty_next, fifo_pushed;
    logic [DROP_W-1:0] drop_cnt;
    logic              wr_st, wr_thr, pop_req;
    logic [3:0]        w1c, set_ev;

    cir_rx_sampler #(.TICK_CYCLES(TICK_CYCLES)) u_smp (
        .clk(clk), .rst_n(rst_n), .en(blk_en), .ir_in(ir_in),
        .tick(tick), .level(level)
    );

    cir_rx_runlen #(.THR_W(THR_W)) u_rl (
        .clk(clk), .rst_n(rst_n), .en(blk_en), .tick(tick), .level(level),
        .idle_thr(core_q.thr), .push(rl_push), .push_byte(rl_byte),
        .idle_hit(idle_hit)
    );

    cir_rx_fifo #(.DEPTH(FIFO_DEPTH), .W(BYTE_W), .CNT_W(DROP_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(rl_push), .wdata(rl_byte),
        .pop(pop_req), .head(fifo_head), .empty(fifo_empty), .full(fifo_full),
        .empty_next(fifo_empty_next), .pushed(fifo_pushed), .drop_cnt(drop_cnt)
    );

    always_comb begin
        wr_st   = blk_en && reg_wr && (reg_sel_e'(reg_addr) == SEL_STATUS);
        wr_thr  = blk_en && reg_wr && (reg_sel_e'(reg_addr) == SEL_IDLE);
        pop_req = blk_en && reg_rd && (reg_sel_e'(reg_addr) == SEL_RXDATA);

        w1c = wr_st ? reg_wdata[3:0] : 4'h0;
        set_ev = '0;
        set_ev[F_RXDATA] = fifo_pushed;
        set_ev[F_RXTMO]  = idle_hit && !fifo_empty_next;
        set_ev[F_TXUND]  = blk_en && tx_underrun_evt;
        set_ev[F_TXDONE] = blk_en && tx_done_evt;

        core_d = core_q;
        // transmit flags: write-1-to-clear, a new event wins
        core_d.st.flags[F_TXDONE:F_TXUND] =
            (core_q.st.flags[F_TXDONE:F_TXUND] & ~w1c[F_TXDONE:F_TXUND])
            | set_ev[F_TXDONE:F_TXUND];
        // receive flags follow the queue: they drop only once it drains
        core_d.st.flags[F_RXTMO:F_RXDATA] = fifo_empty_next ? 2'b00 :
            (core_q.st.flags[F_RXTMO:F_RXDATA] | set_ev[F_RXTMO:F_RXDATA]);
        if (wr_st)  core_d.st.irq_en = reg_wdata[IRQEN_BIT];
        if (wr_thr) core_d.thr       = reg_wdata;
    end

    always_comb begin
        if (!blk_en) begin
            reg_rdata = '1;
        end else begin
            unique case (reg_sel_e'(reg_addr))
                SEL_STATUS: reg_rdata = {core_q.st.irq_en, 3'b000, core_q.st.flags};
                SEL_RXDATA: reg_rdata = fifo_empty ? '0 : fifo_head;
                SEL_IDLE:   reg_rdata = core_q.thr;
                default:    reg_rdata = drop_cnt;
            endcase
        end
    end

    assign irq = core_q.st.irq_en && (|core_q.st.flags);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_q <= CORE_RST;
        else        core_q <= core_d;
    end
endmodule

// File: rtl/cir_rx_chk.sv
module cir_rx_chk
    import cir_rx_pkg::*;
#(
    parameter int DROP_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              blk_en,
    input logic              irq,
    input status_t           st,
    input logic              fifo_empty,
    input logic              fifo_full,
    input logic              push,
    input run_byte_t         push_byte,
    input logic              pop,
    input logic [DROP_W-1:0] drop_cnt,
    input logic              reg_wr,
    input logic [1:0]        reg_addr,
    input logic [7:0]        reg_wdata,
    input logic              tx_und_evt
);
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> st.irq_en); // R10

    AST_RXFLAGS_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_empty |-> (st.flags[F_RXTMO:F_RXDATA] == 2'b00)); // R9

    AST_DROP_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
        (push && fifo_full && !pop && !(&drop_cnt)) |=> (drop_cnt == $past(drop_cnt) + 1'b1)); // R6

    AST_RUN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (push_byte.ticks != '0)); // R2

    AST_ZERO_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_en && reg_wr && reg_addr == 2'd0 && !reg_wdata[F_TXUND] && st.flags[F_TXUND])
        |=> st.flags[F_TXUND]); // R8

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_en && tx_und_evt) |=> st.flags[F_TXUND]); // R8
endmodule

bind cir_rx_top cir_rx_chk #(.DROP_W(DROP_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .blk_en(blk_en), .irq(irq), .st(core_q.st),
    .fifo_empty(fifo_empty), .fifo_full(fifo_full), .push(rl_push),
    .push_byte(rl_byte), .pop(pop_req), .drop_cnt(drop_cnt), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .tx_und_evt(tx_underrun_evt)
);

// File: tb/cir_rx_top_tb_top.sv
module cir_rx_top_tb_top;
    localparam int TICK = 4;
    localparam int THR  = 10;
    localparam int NVEC = 6;
    // pulse ticks, expected byte count (pulse bytes + one space byte), last pulse byte
    localparam int VEC_TICKS [NVEC] = '{1, 5, 126, 127, 128, 300};
    localparam int VEC_NB    [NVEC] = '{2, 2, 2, 2, 3, 4};
    localparam int VEC_TAIL  [NVEC] = '{8'h81, 8'h85, 8'hFE, 8'hFF, 8'h81, 8'hAE};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       blk_en = 1'b1;
    logic       ir_in = 1'b0;
    logic       tx_und = 1'b0;
    logic       tx_done = 1'b0;
    logic [1:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq;

    int  n_checks = 0;
    int  n_err = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    cir_rx_top #(.TICK_CYCLES(TICK), .FIFO_DEPTH(16), .IDLE_DEF(THR)) dut_i (
        .clk(clk), .rst_n(rst_n), .blk_en(blk_en), .ir_in(ir_in),
        .tx_underrun_evt(tx_und), .tx_done_evt(tx_done), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic expect_reg(input string req, input logic [1:0] a, input logic [7:0] exp);
        logic [7:0] v;
        reg_read(a, v);
        check(req, v, exp);
    endtask

    task automatic send_run(input logic lv, input int ticks);
        ir_in = lv;
        repeat (ticks * TICK) @(negedge clk);
    endtask

    task automatic strobe_und();
        @(negedge clk); tx_und = 1'b1;
        @(negedge clk); tx_und = 1'b0;
    endtask

    task automatic strobe_done();
        @(negedge clk); tx_done = 1'b1;
        @(negedge clk); tx_done = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        expect_reg("R1 status", 2'd0, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);
        expect_reg("R1 data", 2'd1, 8'h00);
        expect_reg("R1 threshold", 2'd2, THR[7:0]);
        expect_reg("R1 drops", 2'd3, 8'h00);

        // R7 enable bit written, bits 6:4 read zero
        reg_write(2'd0, 8'hF0);
        expect_reg("R7 status layout", 2'd0, 8'h80);

        // table of pulse lengths: R2 R3 R4 R9 R10
        for (int i = 0; i < NVEC; i++) begin
            send_run(1'b1, VEC_TICKS[i]);
            send_run(1'b0, THR + 5);
            expect_reg("R9 rx flags set", 2'd0, 8'h83);
            check("R10 irq on rx", {7'd0, irq}, 8'h01);
            if (i == 0) begin
                reg_write(2'd0, 8'h83);
                expect_reg("R9 write ignored while queued", 2'd0, 8'h83);
            end
            for (int k = 0; k < VEC_NB[i]; k++) begin
                logic [7:0] exp_b, got;
                if (k < VEC_NB[i] - 2)       exp_b = 8'hFF;
                else if (k == VEC_NB[i] - 2) exp_b = VEC_TAIL[i][7:0];
                else                         exp_b = THR[7:0];
                reg_read(2'd1, got);
                check((k == VEC_NB[i] - 1) ? "R4 closing space" : "R2 R3 pulse byte", got, exp_b);
            end
            expect_reg("R9 flags clear on drain", 2'd0, 8'h80);
        end

        // R3 split of a long space with idle detection off (R4)
        reg_write(2'd2, 8'h00);
        send_run(1'b1, 2);
        send_run(1'b0, 130);
        ir_in = 1'b1;
        reg_write(2'd2, THR[7:0]);
        repeat (2) @(negedge clk);
        send_run(1'b0, THR + 5);
        expect_reg("R3 pulse", 2'd1, 8'h82);
        expect_reg("R3 space full chunk", 2'd1, 8'h7F);
        expect_reg("R3 space remainder", 2'd1, 8'h03);
        expect_reg("R4 next pulse", 2'd1, 8'h81);
        expect_reg("R4 closing space", 2'd1, THR[7:0]);
        expect_reg("R5 empty read", 2'd1, 8'h00);

        // R6 overflow: 20 pulse bytes plus a space byte into 16 entries
        send_run(1'b1, 127 * 20);
        send_run(1'b0, THR + 5);
        expect_reg("R9 timeout with full queue", 2'd0, 8'h83);
        expect_reg("R6 drop count", 2'd3, 8'd5);
        for (int k = 0; k < 16; k++) begin
            logic [7:0] got;
            reg_read(2'd1, got);
            check("R5 R6 kept byte", got, 8'hFF);
        end
        expect_reg("R5 read when empty", 2'd1, 8'h00);
        expect_reg("R9 drained", 2'd0, 8'h80);

        // R8 transmit flags and R10
        strobe_und();
        expect_reg("R8 underrun set", 2'd0, 8'h84);
        check("R10 irq on tx", {7'd0, irq}, 8'h01);
        reg_write(2'd0, 8'h80);
        expect_reg("R8 zero write keeps", 2'd0, 8'h84);
        strobe_done();
        expect_reg("R8 done set", 2'd0, 8'h8C);
        reg_write(2'd0, 8'h84);
        expect_reg("R8 w1c one bit", 2'd0, 8'h88);
        // same cycle: clearing write and new done event
        @(negedge clk);
        reg_addr = 2'd0; reg_wdata = 8'h88; reg_wr = 1'b1; tx_done = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; tx_done = 1'b0;
        expect_reg("R8 event wins over clear", 2'd0, 8'h88);
        check("R10 irq held", {7'd0, irq}, 8'h01);
        reg_write(2'd0, 8'h88);
        expect_reg("R8 cleared", 2'd0, 8'h80);
        check("R10 irq low with no flag", {7'd0, irq}, 8'h00);
        strobe_und();
        reg_write(2'd0, 8'h00);
        expect_reg("R10 enable off keeps flag", 2'd0, 8'h04);
        check("R10 irq masked", {7'd0, irq}, 8'h00);
        reg_write(2'd0, 8'h84);
        expect_reg("R8 clear with enable", 2'd0, 8'h80);

        // R11 block disabled
        send_run(1'b1, 3);
        send_run(1'b0, THR + 5);
        @(negedge clk); blk_en = 1'b0;
        expect_reg("R11 status absent", 2'd0, 8'hFF);
        expect_reg("R11 data absent", 2'd1, 8'hFF);
        reg_write(2'd2, 8'h33);
        reg_write(2'd0, 8'h03);
        @(negedge clk); blk_en = 1'b1;
        expect_reg("R11 threshold kept", 2'd2, THR[7:0]);
        expect_reg("R11 status kept", 2'd0, 8'h83);
        expect_reg("R11 no pop pulse", 2'd1, 8'h83);
        expect_reg("R11 no pop space", 2'd1, THR[7:0]);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end
endmodule